// File: doc/BRIEF.md
# Peripheral Run-State Controller

This block holds the operating state of a serial peripheral and moves it between reset, run and pause on request from software. Software writes a 2-bit request code through a simple write port. The block reports a valid flag, which stays low for a fixed settling window after every accepted request. Software must see the flag high before it sends the next request. The block drives the data-path controls from its current state: a shifter enable, an output-FIFO push enable, a level that holds counters and error flags clear, and a one-cycle flush pulse.

The only way out of pause into reset is a run of consecutive clear-code writes (two by default). A single clear write leaves the block in pause. Any other accepted write in the middle of the run restarts it. A software-reset strobe forces the block into reset from any state.

Top module: `rsc_run_ctrl`

## Requirements
- R1: When rst_ni is asserted, the block holds state 0 (reset) with valid high, dp_clear_o high, flush_o low, shift_en_o low and ofifo_en_o low.
- R2: A write is accepted when wr_en_i is high, valid_o is high and sw_reset_i is low. valid_o goes low on the edge that accepts the write. It stays low for exactly SETTLE_CYCLES cycles and then rises.
- R3: A write presented while valid_o is low is ignored. The state does not change and the settling window is not restarted.
- R4: The request codes are 0 = reset, 1 = run, 3 = pause and 2 = clear. An accepted write of 0, 1 or 3 sets state_o to that code on the accepting edge, with the single exception of a write of 0 while in pause.
- R5: In pause, CLEAR_WRITES consecutive accepted writes of code 2 move the block to reset. Any shorter run leaves it in pause.
- R6: The count of clear writes returns to zero after any accepted write of another code and after a software reset.
- R7: A write of 0 while in pause leaves the block in pause. A write of 2 while in run or in reset changes nothing.
- R8: A high sw_reset_i forces state 0 on the next edge from any state. It takes priority over a write presented in the same cycle, and it drops valid_o for SETTLE_CYCLES cycles.
- R9: dp_clear_o is high in every cycle the state is reset. flush_o is high for exactly one cycle, the first cycle after the state changes into reset from another state.
- R10: shift_en_o is high only when the state is run and valid_o is high. ofifo_en_o is high whenever the state is run or pause.
- R11: rd_data_o bits [1:0] carry the current state code and bit 2 carries valid_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | State register write strobe |
| wr_data_i | input | 2 | Requested state code |
| sw_reset_i | input | 1 | One-cycle software reset strobe |
| rd_data_o | output | 3 | Register read value {valid, state} |
| state_o | output | 2 | Current state code |
| valid_o | output | 1 | Current state is in effect |
| shift_en_o | output | 1 | Shifter enable |
| ofifo_en_o | output | 1 | Output FIFO push enable |
| dp_clear_o | output | 1 | Hold counters and error flags clear |
| flush_o | output | 1 | One-cycle FIFO flush on entry to reset |

## Verification
The bench builds the block with SETTLE_CYCLES = 3 and CLEAR_WRITES = 2. Because the window is longer than one cycle, a request can be placed inside it, which exercises the ignore path. The length of the low window can also be counted exactly. With two clear writes, the bench can place an interrupting pause write or a software reset between two clears and check that the clear count restarts.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  typedef enum logic [1:0] {
    CODE_RESET = 2'd0,
    CODE_RUN   = 2'd1,
    CODE_CLEAR = 2'd2,
    CODE_PAUSE = 2'd3
  } rsc_code_e;
endpackage

// File: rtl/rsc_settle_timer.sv
module rsc_settle_timer #(
  parameter int unsigned SETTLE_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic valid_o
);
  localparam int unsigned CW = (SETTLE_CYCLES < 1) ? 1 : $clog2(SETTLE_CYCLES + 1);

  generate
    if (SETTLE_CYCLES == 0) begin : g_none
      assign valid_o = 1'b1;
    end else begin : g_cnt
      localparam logic [CW-1:0] LOAD = CW'(SETTLE_CYCLES);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              cnt_q <= '0;
        else if (start_i)         cnt_q <= LOAD;
        else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
      end
      assign valid_o = (cnt_q == '0);
    end
  endgenerate
endmodule

// File: rtl/rsc_clear_seq.sv
module rsc_clear_seq
  import rsc_pkg::*;
#(
  parameter int unsigned CLEAR_WRITES = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      accept_i,
  input  rsc_code_e code_i,
  input  logic      in_pause_i,
  input  logic      sw_reset_i,
  output logic      clear_done_o
);
  localparam int unsigned NW = (CLEAR_WRITES < 2) ? 2 : CLEAR_WRITES;
  localparam int unsigned SW = $clog2(NW);
  localparam logic [SW-1:0] LAST = SW'(NW - 1);

  logic [SW-1:0] seen_q;
  logic          clr_hit;

  assign clr_hit = accept_i && in_pause_i && (code_i == CODE_CLEAR);

  generate
    if (CLEAR_WRITES <= 1) begin : g_single
      assign clear_done_o = clr_hit;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) seen_q <= '0;
        else         seen_q <= '0;
      end
    end else begin : g_multi
      assign clear_done_o = clr_hit && (seen_q == LAST);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                       seen_q <= '0;
        else if (sw_reset_i)               seen_q <= '0;
        else if (accept_i) begin
          if (clr_hit && seen_q != LAST)   seen_q <= seen_q + 1'b1;
          else                             seen_q <= '0;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/rsc_state_fsm.sv
module rsc_state_fsm
  import rsc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      accept_i,
  input  rsc_code_e code_i,
  input  logic      clear_done_i,
  input  logic      sw_reset_i,
  output rsc_code_e state_o,
  output logic      flush_o
);
  rsc_code_e state_q, state_d;
  logic      flush_q;

  always_comb begin
    state_d = state_q;
    if (sw_reset_i) begin
      state_d = CODE_RESET;
    end else if (accept_i) begin
      unique case (code_i)
        CODE_RUN:   state_d = CODE_RUN;
        CODE_PAUSE: state_d = CODE_PAUSE;
        // leaving pause for reset needs the clear run
        CODE_RESET: if (state_q != CODE_PAUSE) state_d = CODE_RESET;
        CODE_CLEAR: if (clear_done_i) state_d = CODE_RESET;
        default:    state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CODE_RESET;
      flush_q <= 1'b0;
    end else begin
      state_q <= state_d;
      flush_q <= (state_d == CODE_RESET) && (state_q != CODE_RESET);
    end
  end

  assign state_o = state_q;
  assign flush_o = flush_q;
endmodule

// File: rtl/rsc_run_ctrl.sv
module rsc_run_ctrl
  import rsc_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 4,
  parameter int unsigned CLEAR_WRITES  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [1:0] wr_data_i,
  input  logic       sw_reset_i,
  output logic [2:0] rd_data_o,
  output logic [1:0] state_o,
  output logic       valid_o,
  output logic       shift_en_o,
  output logic       ofifo_en_o,
  output logic       dp_clear_o,
  output logic       flush_o
);
  rsc_code_e code, state;
  logic      valid, accept, clear_done;

  assign code   = rsc_code_e'(wr_data_i);
  assign accept = wr_en_i && valid && !sw_reset_i;

  rsc_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept || sw_reset_i),
    .valid_o (valid)
  );

  rsc_clear_seq #(.CLEAR_WRITES(CLEAR_WRITES)) u_clr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .accept_i     (accept),
    .code_i       (code),
    .in_pause_i   (state == CODE_PAUSE),
    .sw_reset_i   (sw_reset_i),
    .clear_done_o (clear_done)
  );

  rsc_state_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .accept_i     (accept),
    .code_i       (code),
    .clear_done_i (clear_done),
    .sw_reset_i   (sw_reset_i),
    .state_o      (state),
    .flush_o      (flush_o)
  );

  assign state_o    = state;
  assign valid_o    = valid;
  assign rd_data_o  = {valid, state};
  assign shift_en_o = (state == CODE_RUN) && valid;
  assign ofifo_en_o = (state == CODE_RUN) || (state == CODE_PAUSE);
  assign dp_clear_o = (state == CODE_RESET);
endmodule

// File: rtl/rsc_run_ctrl_chk.sv
module rsc_run_ctrl_chk #(
  parameter int unsigned SETTLE_CYCLES = 4,
  parameter int unsigned CLEAR_WRITES  = 2
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [1:0] wr_data_i,
  input logic       sw_reset_i,
  input logic [2:0] rd_data_o,
  input logic [1:0] state_o,
  input logic       valid_o,
  input logic       shift_en_o,
  input logic       ofifo_en_o,
  input logic       dp_clear_o,
  input logic       flush_o
);
  logic [31:0] low_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       low_cnt <= '0;
    else if (!valid_o) low_cnt <= low_cnt + 1;
    else               low_cnt <= '0;
  end

  // R2: low window never exceeds the settle length
  always_ff @(posedge clk_i) begin
    if (rst_ni) p_low_window_r2: assert (low_cnt <= SETTLE_CYCLES);
  end

  p_accept_drops_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (SETTLE_CYCLES > 0 && wr_en_i && valid_o && !sw_reset_i) |=> !valid_o);

  p_ignored_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !valid_o && !sw_reset_i) |=> $stable(state_o));

  p_run_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && valid_o && !sw_reset_i && wr_data_i == 2'd1) |=> state_o == 2'd1);

  p_pause_exit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd3 && !sw_reset_i && !(wr_en_i && wr_data_i == 2'd2)) |=> state_o != 2'd0);

  p_sw_reset_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_reset_i |=> (state_o == 2'd0 && (SETTLE_CYCLES == 0 || !valid_o)));

  p_flush_in_reset_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> dp_clear_o);

  p_shift_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_o |-> (state_o == 2'd1 && valid_o && ofifo_en_o));
endmodule

bind rsc_run_ctrl rsc_run_ctrl_chk #(
  .SETTLE_CYCLES(SETTLE_CYCLES),
  .CLEAR_WRITES (CLEAR_WRITES)
) u_chk (.*);

// File: tb/rsc_run_ctrl_tb.sv
`timescale 1ns/1ps
module rsc_run_ctrl_tb;
  localparam int S = 3;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_data_i = 2'd0;
  logic       sw_reset_i = 1'b0;
  logic [2:0] rd_data_o;
  logic [1:0] state_o;
  logic       valid_o, shift_en_o, ofifo_en_o, dp_clear_o, flush_o;

  int tests = 0;
  int fails = 0;

  always #10 clk_i = ~clk_i;

  rsc_run_ctrl #(.SETTLE_CYCLES(S), .CLEAR_WRITES(2)) u_dut (.*);

  // {write code, expected state}
  localparam int NV = 15;
  localparam logic [3:0] VEC [0:NV-1] = '{
    4'b01_01, 4'b11_11, 4'b01_01, 4'b00_00, 4'b11_11,
    4'b10_11, 4'b10_00, 4'b01_01, 4'b10_01, 4'b11_11,
    4'b00_11, 4'b10_11, 4'b11_11, 4'b10_11, 4'b10_00
  };

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_valid();
    for (int i = 0; i < 100 && !valid_o; i++) @(negedge clk_i);
  endtask

  task automatic do_write(input logic [1:0] c);
    wait_valid();
    wr_en_i = 1'b1; wr_data_i = c;
    @(posedge clk_i); @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic count_low(output int n);
    n = 0;
    while (!valid_o && n < 100) begin n++; @(negedge clk_i); end
  endtask

  task automatic pulse_sw(input logic with_wr);
    sw_reset_i = 1'b1; wr_en_i = with_wr; wr_data_i = 2'd3;
    @(posedge clk_i); @(negedge clk_i);
    sw_reset_i = 1'b0; wr_en_i = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    logic [1:0] prev;
    repeat (3) @(negedge clk_i);
    chk("R1 state", state_o, 0);
    chk("R1 valid", valid_o, 1);
    chk("R1 dp_clear", dp_clear_o, 1);
    chk("R1 shift_en", shift_en_o, 0);
    chk("R1 ofifo_en", ofifo_en_o, 0);
    chk("R1 flush", flush_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    prev = 2'd0;
    for (int k = 0; k < NV; k++) begin
      do_write(VEC[k][3:2]);
      chk($sformatf("R4 R5 R6 R7 vec%0d state", k), state_o, VEC[k][1:0]);
      chk("R2 valid low after write", valid_o, 0);
      chk("R10 shift_en in settle", shift_en_o, 0);
      chk("R9 flush", flush_o, (VEC[k][1:0] == 2'd0 && prev != 2'd0) ? 1 : 0);
      count_low(n);
      chk("R2 low window", n, S);
      chk("R11 rd_data", rd_data_o, {1'b1, VEC[k][1:0]});
      chk("R10 shift_en", shift_en_o, (VEC[k][1:0] == 2'd1) ? 1 : 0);
      chk("R10 ofifo_en", ofifo_en_o, (VEC[k][1:0] == 2'd1 || VEC[k][1:0] == 2'd3) ? 1 : 0);
      chk("R9 dp_clear", dp_clear_o, (VEC[k][1:0] == 2'd0) ? 1 : 0);
      prev = VEC[k][1:0];
    end

    // R3: write during the settle window is ignored
    do_write(2'd3);
    wr_en_i = 1'b1; wr_data_i = 2'd1;
    @(posedge clk_i); @(negedge clk_i);
    wr_en_i = 1'b0;
    chk("R3 state kept", state_o, 3);
    count_low(n);
    chk("R3 window not restarted", n, S - 1);
    chk("R3 state after settle", state_o, 3);

    // R8: sw reset beats a simultaneous write, from run
    do_write(2'd1); wait_valid();
    pulse_sw(1'b1);
    chk("R8 state", state_o, 0);
    chk("R8 valid low", valid_o, 0);
    chk("R9 flush on sw reset", flush_o, 1);
    @(negedge clk_i);
    chk("R9 flush one cycle", flush_o, 0);
    count_low(n);
    chk("R8 window", n, S - 1);

    // R9: sw reset while already in reset gives no flush
    pulse_sw(1'b0);
    chk("R9 no flush in reset", flush_o, 0);
    chk("R8 state stays", state_o, 0);
    wait_valid();

    // R6: sw reset clears an armed clear count
    do_write(2'd3);
    do_write(2'd2);
    chk("R5 single clear keeps pause", state_o, 3);
    wait_valid();
    pulse_sw(1'b0);
    chk("R8 from pause", state_o, 0);
    do_write(2'd3);
    do_write(2'd2);
    chk("R6 count restarted by sw reset", state_o, 3);
    do_write(2'd2);
    chk("R5 second clear", state_o, 0);
    wait_valid();

    // R1: asynchronous reset in run
    do_write(2'd1); wait_valid();
    #3 rst_ni = 1'b0;
    #2;
    chk("R1 async state", state_o, 0);
    chk("R1 async valid", valid_o, 1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 shift after reset", shift_en_o, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule